// File: doc/BRIEF.md
# ADC Serial Result Output Register

This block is the device-side readout logic of a 14-bit sampling converter. A host starts a conversion by pulling an active-low convert-start strobe low. The block raises a busy flag at that point. A behavioural conversion timer later signals that the conversion is done, and gives the result on a parallel bus. At that moment the block drops busy and loads a 16-bit frame into its output register. The frame is two zero pad bits followed by the 14-bit result.

The host is always the serial master. It supplies the serial clock, and the block moves one bit per rising clock edge onto its serial data output, most significant bit first. A master set for clock idle low, sampling on the trailing edge, therefore reads each bit on the falling edge. The serial clock may stop and restart anywhere in the frame, so the frame can be read in several short bursts.

The bit position counter is resynchronised on the falling edge of convert-start, but only when the serial clock is low at that edge. Both asynchronous inputs pass through a synchroniser into the block's clock domain before edges are detected.

Top module: `adc_serial_readout`

## Requirements
- R1: While reset is high and on the first cycle after it, busy and sdata are 0 and the bit position is 0, the idle position.
- R2: A falling edge of conv_start_n sets busy, which then stays 1 until a conversion-done event is accepted.
- R3: A conv_done pulse while busy is 1 clears busy and loads the frame. Frame bits 15 and 14 are 0 and bits 13..0 are the result bus.
- R4: A conv_done pulse while busy is 0 is ignored: busy stays 0 and the stored frame and the bits read out afterwards are unchanged.
- R5: Rising serial clock edge number k (k = 1..16) after a position reset drives frame bit 16-k onto sdata. Position 0, before the first edge, drives 0.
- R6: After the sixteenth rising edge, further rising edges drive 0 on sdata. The position does not wrap until the next qualified reset.
- R7: A falling edge of conv_start_n while the synchronised serial clock is low resets the bit position to 0 and clears the frame to all zeros.
- R8: A falling edge of conv_start_n while the synchronised serial clock is high still sets busy, but leaves the bit position and the frame unchanged.
- R9: The serial clock may pause for any number of cycles between edges. The bit position is held, and the read continues where it stopped.
- R10: sclk and conv_start_n pass through SYNC_STAGES flip-flops. A change on either input that is first sampled at clock edge e takes effect at edge e+SYNC_STAGES.
- R11: If a conversion-done event and an effective rising serial clock edge fall in the same cycle, both apply: the new frame is loaded and the position advances, so sdata shows the new frame's bit. If a convert-start fall and conv_done fall in the same cycle, the start wins: busy stays 1 and conv_done is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_n | input | 1 | Active-low convert-start strobe (asynchronous) |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| conv_done | input | 1 | One-cycle conversion-complete pulse from the timer |
| result | input | 14 | Conversion result, sampled on an accepted conv_done |
| busy | output | 1 | High from convert start until the result is loaded |
| sdata | output | 1 | Serial data, MSB first, changes on the rising edge of sclk |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a frame load and a shift advance. The second pair is a convert-start fall and a conversion-done event. The first pair is provoked by raising the serial clock and then sweeping the conv_done pulse across several offsets. Because conv_done enters unsynchronised while sclk goes through the synchroniser delay, one offset makes the two coincide. The second pair is provoked the same way with the strobe, sweeping conv_done across the strobe's synchroniser delay. A behavioural model in the bench predicts busy and sdata every cycle. The bits the master captures after each collision are also compared with the frame the requirements say must appear.

// File: rtl/adc_ro_pkg.sv
package adc_ro_pkg;

    localparam int RES_W   = 14;
    localparam int FRAME_W = 16;
    localparam int PAD_W   = FRAME_W - RES_W;
    localparam int LAST_POS = FRAME_W + 1;
    localparam int CNT_W   = $clog2(LAST_POS + 1);
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef logic [RES_W-1:0]   result_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CNT_W-1:0]   pos_t;

    // per-cycle control decisions made at the top
    typedef struct packed {
        logic start_fall;
        logic reseed;
        logic shift_rise;
        logic load;
    } ctl_t;

    function automatic frame_t make_frame(input result_t r);
        return {{PAD_W{1'b0}}, r};
    endfunction

    // position 1..FRAME_W selects frame bit FRAME_W-pos, else quiet
    function automatic logic pick_bit(input frame_t f, input pos_t p);
        logic [IDX_W-1:0] idx;
        idx = IDX_W'(FRAME_W - int'(p));
        if (p >= pos_t'(1) && p <= pos_t'(FRAME_W))
            return f[idx];
        return 1'b0;
    endfunction

endpackage

// File: rtl/adc_ro_sync.sv
module adc_ro_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_ro_edge.sv
module adc_ro_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/adc_ro_bitcnt.sv
module adc_ro_bitcnt
    import adc_ro_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output pos_t pos
);
    localparam pos_t LAST = pos_t'(LAST_POS);

    pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst)                         pos_q <= '0;
        else if (clear)                  pos_q <= '0;
        else if (step && pos_q != LAST)  pos_q <= pos_q + 1'b1;
    end

    assign pos = pos_q;

    // R7
    reseed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> pos_q == '0);

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && pos_q == LAST) |=> pos_q == LAST);

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && pos_q != LAST) |=> pos_q == $past(pos_q) + 1'b1);

    // R9
    hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(pos_q));
endmodule

// File: rtl/adc_ro_frame.sv
module adc_ro_frame
    import adc_ro_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    load,
    input  result_t result,
    output frame_t  frame
);
    frame_t frame_q;

    always_ff @(posedge clk) begin
        if (rst)        frame_q <= '0;
        else if (clear) frame_q <= '0;
        else if (load)  frame_q <= make_frame(result);
    end

    assign frame = frame_q;

    // R3
    load_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> frame_q[FRAME_W-1 -: PAD_W] == '0 &&
                             frame_q[RES_W-1:0] == $past(result));

    // R8
    hold_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load) |=> $stable(frame_q));
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
    import adc_ro_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start_n,
    input  logic             sclk,
    input  logic             conv_done,
    input  logic [RES_W-1:0] result,
    output logic             busy,
    output logic             sdata
);
    // bit 1: strobe (idles high), bit 0: serial clock (idles low)
    localparam logic [1:0] IN_IDLE = 2'b10;

    logic [1:0] in_sync;
    logic [1:0] in_rise;
    logic [1:0] in_fall;
    ctl_t       ctl;
    logic       busy_q;
    pos_t       pos;
    frame_t     frame;

    adc_ro_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({conv_start_n, sclk}),
        .q   (in_sync)
    );

    adc_ro_edge #(.W(2), .RST_VAL(IN_IDLE)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (in_sync),
        .rise (in_rise),
        .fall (in_fall)
    );

    always_comb begin
        ctl.start_fall = in_fall[1];
        ctl.reseed     = in_fall[1] & ~in_sync[0];
        ctl.shift_rise = in_rise[0];
        ctl.load       = conv_done & busy_q & ~in_fall[1];
    end

    always_ff @(posedge clk) begin
        if (rst)                 busy_q <= 1'b0;
        else if (ctl.start_fall) busy_q <= 1'b1;
        else if (ctl.load)       busy_q <= 1'b0;
    end

    adc_ro_bitcnt u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.reseed),
        .step  (ctl.shift_rise),
        .pos   (pos)
    );

    adc_ro_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctl.reseed),
        .load   (ctl.load),
        .result (result),
        .frame  (frame)
    );

    assign busy  = busy_q;
    assign sdata = pick_bit(frame, pos);

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.start_fall |=> busy);

    // R3
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && busy && !ctl.start_fall) |=> !busy);

    // R4
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !busy && !ctl.start_fall) |=> !busy && $stable(frame));

    // R6
    quiet_outside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (pos == '0 || pos > pos_t'(FRAME_W)) |-> !sdata);

    // R11
    start_beats_done_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.start_fall && conv_done) |=> busy);

    // R8
    unqualified_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.start_fall && in_sync[0]) |=> $stable(pos));
endmodule

// File: tb/tb_adc_serial_readout.sv
module tb_adc_serial_readout;
    localparam int SYNC = 2;
    localparam int HALF = 4;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_n = 1'b1;
    logic        sclk = 1'b0;
    logic        done = 1'b0;
    logic [13:0] res = '0;
    logic        busy;
    logic        sdata;

    int vectors = 0;
    int misses = 0;
    int cycles = 0;
    string tag = "R1";

    adc_serial_readout #(.SYNC_STAGES(SYNC)) dut (
        .clk          (clk),
        .rst          (rst),
        .conv_start_n (conv_n),
        .sclk         (sclk),
        .conv_done    (done),
        .result       (res),
        .busy         (busy),
        .sdata        (sdata)
    );

    always #10 clk = ~clk;

    // behavioural reference: input history, busy flag, position, frame
    logic [7:0] hs = 8'h00;
    logic [7:0] hc = 8'hFF;
    bit m_busy = 0;
    int m_pos = 0;
    int m_frame = 0;

    always @(posedge clk) begin
        hs = {hs[6:0], sclk};
        hc = {hc[6:0], conv_n};
        if (rst) begin
            m_busy = 0; m_pos = 0; m_frame = 0;
        end else begin
            bit sf, rz, rs, ld;
            sf = hc[SYNC+1] && !hc[SYNC];
            rz = sf && !hs[SYNC];
            rs = hs[SYNC] && !hs[SYNC+1];
            ld = done && m_busy && !sf;
            if (sf) m_busy = 1; else if (ld) m_busy = 0;
            if (rz) m_frame = 0; else if (ld) m_frame = int'(res);
            if (rz) m_pos = 0; else if (rs && m_pos < 17) m_pos++;
        end
    end

    function automatic bit exp_sdata();
        if (m_pos >= 1 && m_pos <= 16) return 1'((m_frame >> (16 - m_pos)) & 1);
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        bit e;
        e = exp_sdata();
        cycles++;
        vectors++;
        if (busy !== m_busy || sdata !== e) begin
            misses++;
            $display("FAIL %s busy=%0b exp %0b sdata=%0b exp %0b", tag, busy, m_busy, sdata, e);
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_conv();
        @(negedge clk); conv_n = 1'b0;
        tick(2); conv_n = 1'b1;
        tick(SYNC + 2);
    endtask

    task automatic done_pulse(input logic [13:0] r);
        @(negedge clk); res = r; done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic read_bits(input int n, inout int cap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sclk = 1'b1;
            tick(HALF);
            cap = (cap << 1) | int'(sdata);
            sclk = 1'b0;
            tick(HALF);
        end
    endtask

    initial begin
        int cap;
        tick(3);
        chk("R1 busy", int'(busy), 0);
        chk("R1 sdata", int'(sdata), 0);
        @(negedge clk); rst = 1'b0;
        chk("R1 busy after release", int'(busy), 0);

        // R10 latency through the synchroniser
        tag = "R10";
        @(negedge clk); conv_n = 1'b0;
        tick(SYNC);
        chk("R10 busy before sync delay", int'(busy), 0);
        tick(1);
        chk("R10 busy after sync delay", int'(busy), 1);
        conv_n = 1'b1;
        tick(4);

        // R2 / R3 / R5 / R6 full read
        tag = "R3";
        tick(20);
        chk("R2 busy held", int'(busy), 1);
        done_pulse(14'h2A5C);
        chk("R3 busy cleared", int'(busy), 0);
        tag = "R5";
        cap = 0;
        read_bits(16, cap);
        chk("R5 frame msb first", cap, 32'h2A5C);
        tag = "R6";
        cap = 0;
        read_bits(5, cap);
        chk("R6 bits past sixteen", cap, 0);

        // R7 / R4: qualified reset, then idle done ignored mid read
        tag = "R7";
        start_conv();
        chk("R7 sdata after reseed", int'(sdata), 0);
        done_pulse(14'h3FFF);
        tag = "R4";
        cap = 0;
        read_bits(8, cap);
        done_pulse(14'h0000);
        chk("R4 busy stays low", int'(busy), 0);
        read_bits(8, cap);
        chk("R4 frame kept", cap, 32'h3FFF);

        // R9 bursts with pauses
        tag = "R9";
        start_conv();
        done_pulse(14'h1B37);
        cap = 0;
        read_bits(5, cap);
        tick(37);
        read_bits(3, cap);
        tick(90);
        read_bits(8, cap);
        chk("R9 burst read", cap, 32'h1B37);

        // R8 start fall with sclk high keeps position
        tag = "R8";
        start_conv();
        done_pulse(14'h0F0F);
        cap = 0;
        read_bits(6, cap);
        @(negedge clk); sclk = 1'b1;
        tick(SYNC + 2);
        conv_n = 1'b0;
        tick(2); conv_n = 1'b1;
        tick(SYNC + 2);
        chk("R8 busy set", int'(busy), 1);
        done_pulse(14'h2C71);
        tick(2);
        sclk = 1'b0;
        tick(HALF);
        cap = 0;
        read_bits(9, cap);
        chk("R8 position kept", cap, 32'h2C71 & 32'h1FF);

        // R11 load and shift advance in one cycle
        tag = "R11";
        for (int off = 0; off < 5; off++) begin
            start_conv();
            @(negedge clk); sclk = 1'b1;
            tick(off);
            done_pulse(14'h15A3 ^ 14'(off));
            tick(3);
            sclk = 1'b0;
            tick(HALF);
            cap = 0;
            read_bits(15, cap);
            chk("R11 load with shift", cap, (32'h15A3 ^ off) & 32'h7FFF);
        end

        // R11 start fall and done together
        for (int off = 0; off < 4; off++) begin
            start_conv();
            @(negedge clk); conv_n = 1'b0;
            tick(off);
            done_pulse(14'h0ABC);
            conv_n = 1'b1;
            tick(SYNC + 3);
            done_pulse(14'h0123);
            chk("R11 busy after done", int'(busy), 0);
        end

        tick(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        wait (cycles > WD_LIMIT);
        misses++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule